// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write-Load Controller

This block models the write side of a byte-wide paged nonvolatile memory, run from one synchronous clock. A host drives active-low chip-select, write-strobe and read-strobe levels together with a 15-bit address and 8-bit data. Byte writes collect in a 64-byte page buffer that remembers which byte slots were filled. The load window stays open while bytes keep arriving. Once the gap after the most recent byte grows past a set number of cycles, the window closes and a programming period begins. During that period, only the filled slots are copied into an internal array model.

While programming runs, every read returns end-of-write status instead of array data. Bit 7 is the inverse of bit 7 of the last byte accepted. Bit 6 changes value on each successive read. A host can therefore poll either bit to find out when the write has finished. When the block is idle, reads return the array contents. The array model holds `MODEL_PAGES` pages. To pick a model page, the nine page-address bits are XOR-folded onto log2(`MODEL_PAGES`) bits, so pages 0 to `MODEL_PAGES`-1 map onto themselves. The timing limits are parameters in clock cycles: `BYTE_WIN_CYCLES` is the byte-load window, `PROG_SLOW_CYCLES` is the standard programming period and `PROG_FAST_CYCLES` is the fast one. `FAST_PROG` selects which programming period is used.

Top module: `pgmem_write_ctrl`

## Requirements
- R1: Address bits 14..6 name the page and bits 5..0 name the byte within it. A byte written to an address reads back from that same address once programming has ended.
- R2: `busy` rises at exactly the `BYTE_WIN_CYCLES`-th rising edge after the edge that accepted the last byte of the window.
- R3: Bytes may be loaded in any order. When one offset is written more than once in a single window, the last value written is the one programmed.
- R4: Only the offsets loaded in the window change in the array. Every other byte of that page keeps its earlier value.
- R5: A write strobe whose bits 14..6 differ from the open page is dropped. It does not restart the load window and its data is never programmed.
- R6: `busy` stays high for exactly the selected programming period: `PROG_FAST_CYCLES` when `FAST_PROG`=1, otherwise `PROG_SLOW_CYCLES`. Write strobes that arrive while `busy` is high are ignored and do not open a new window.
- R7: A read that starts while `busy` is high returns bit 7 equal to the complement of bit 7 of the last accepted byte, and bits 5..0 equal to that byte's bits 5..0.
- R8: Bit 6 returned by successive reads during `busy` alternates between 0 and 1. Once `busy` is low, repeated reads return identical true data.
- R9: A write is the period during which `cs_n`=0, `we_n`=0 and `oe_n`=1. The address is sampled on the first clock edge that sees the write active. The data is sampled on the first edge that sees it inactive.
- R10: Reset sets `dout` to 0 and discards any partly loaded page, which is then never programmed. Reset leaves the array contents unchanged.
- R11: A read is the period during which `cs_n`=0, `oe_n`=0 and `we_n`=1. `dout` takes the result on the first clock edge that sees the read active and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | 15 | Byte address: bits 14..6 page, bits 5..0 offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, or end-of-write status while busy |
| busy | output | 1 | High from window close to end of programming |

## Verification
If the filled-slot mask is wrong, the damage appears only after programming ends, as neighbouring bytes of the page that have been overwritten. For that reason, each load is followed by a read-back of all 64 offsets. If the window timer or the page lock is wrong, `busy` rises one or more edges away from its expected edge, so the bench samples `busy` on the exact edges on either side of that rise. If the status path is wrong, bit 7 or bit 6 is already wrong on the very first read during programming.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
// Shared constants and state type for the paged write-load controller.
package pgw_pkg;
    localparam int ADDR_W     = 15;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 6;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int PAGE_W     = ADDR_W - OFS_W;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOAD = 2'd1,
        PG_PROG = 2'd2
    } pg_state_e;
endpackage

// File: rtl/pgw_strobe.sv
`timescale 1ns/1ps
// Strobe qualifier: turns the level-sensitive select/strobe pins into
// single-cycle write and read events.
// Assumes: pins are synchronous to clk. The address is held from the first
// edge a write is seen; the data is taken from din on the edge the write ends.
module pgw_strobe
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_fire
);
    logic wr_now, rd_now, wr_q, rd_q;
    logic [ADDR_W-1:0] addr_q;

    assign wr_now = !cs_n && !we_n && oe_n;
    assign rd_now = !cs_n && !oe_n && we_n;

    // Remember last cycle's strobe levels; latch the address as a write starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            wr_q <= wr_now;
            rd_q <= rd_now;
            if (wr_now && !wr_q) addr_q <= addr;
        end
    end

    assign wr_fire = wr_q && !wr_now;
    assign wr_addr = addr_q;
    assign rd_fire = rd_now && !rd_q;

    // R9: the captured address does not move while a write stays active.
    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && wr_now) |=> $stable(addr_q));
endmodule

// File: rtl/pgw_page_ctrl.sv
`timescale 1ns/1ps
// Page buffer and load-window control. Gathers bytes of a single page,
// tracks which slots are filled, closes the window on inactivity and, during
// programming, offers one filled slot per cycle to the array.
// Assumes: prog_sweep/prog_idx walk offsets 0..PAGE_BYTES-1 once each period.
module pgw_page_ctrl
    import pgw_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 18750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    input  logic              prog_sweep,
    input  logic [OFS_W-1:0]  prog_idx,
    output pg_state_e         st,
    output logic [DATA_W-1:0] last_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int WW = $clog2(WIN_CYCLES + 1);

    pg_state_e              st_q;
    logic [PAGE_W-1:0]      page_q;
    logic [PAGE_BYTES-1:0]  mask_q;
    logic [DATA_W-1:0]      pbuf_q [PAGE_BYTES];
    logic [WW-1:0]          win_q;
    logic [DATA_W-1:0]      last_q;
    logic                   accept, win_hit;
    logic [OFS_W-1:0]       wofs;

    assign wofs    = wr_addr[OFS_W-1:0];
    assign accept  = wr_fire && ((st_q == PG_IDLE) ||
                     (st_q == PG_LOAD && wr_addr[ADDR_W-1:OFS_W] == page_q));
    assign win_hit = (st_q == PG_LOAD) && (win_q == WW'(WIN_CYCLES - 1));

    // Window/programming state sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PG_IDLE;
        else case (st_q)
            PG_IDLE: if (accept) st_q <= PG_LOAD;
            PG_LOAD: if (win_hit && !accept) st_q <= PG_PROG;
            PG_PROG: if (prog_done) st_q <= PG_IDLE;
            default: st_q <= PG_IDLE;
        endcase
    end

    // Inactivity counter: restarts on each accepted byte, idles outside a window.
    always_ff @(posedge clk) begin
        if (!rst_n || accept || st_q != PG_LOAD) win_q <= '0;
        else win_q <= win_q + 1'b1;
    end

    // Page buffer, filled-slot mask, open page and last accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            page_q <= '0;
            last_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= '0;
        end else if (accept) begin
            pbuf_q[wofs]  <= wr_data;
            mask_q[wofs]  <= 1'b1;
            last_q        <= wr_data;
            page_q        <= wr_addr[ADDR_W-1:OFS_W];
        end else if (st_q == PG_PROG && prog_done) begin
            mask_q <= '0;
        end
    end

    assign st        = st_q;
    assign last_data = last_q;
    assign arr_we    = (st_q == PG_PROG) && prog_sweep && mask_q[prog_idx];
    assign arr_addr  = {page_q, prog_idx};
    assign arr_wdata = pbuf_q[prog_idx];

    // R2: the inactivity count never reaches the window length inside a window.
    a_r2_win_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PG_LOAD) |-> (win_q < WW'(WIN_CYCLES)));
    // R5: once a window is open its page cannot be retargeted.
    a_r5_page_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PG_LOAD) |=> $stable(page_q));
    // R6: nothing is loaded while programming runs.
    a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PG_PROG && !prog_done) |=> ($stable(mask_q) && $stable(last_q)));
    // R10: an idle block holds no filled slots.
    a_r10_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PG_IDLE) |-> (mask_q == '0));
endmodule

// File: rtl/pgw_prog_seq.sv
`timescale 1ns/1ps
// Programming period timer. Counts the period while run is high and walks
// the byte offsets during its first PAGE_BYTES cycles.
// Assumes: LIMIT >= PAGE_BYTES (the top clamps it).
module pgw_prog_seq
    import pgw_pkg::*;
#(
    parameter int unsigned LIMIT = 1250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic             done,
    output logic             sweep,
    output logic [OFS_W-1:0] idx
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Period counter: zero whenever not programming.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    assign done  = run && (cnt_q == CW'(LIMIT - 1));
    assign sweep = run && (cnt_q < CW'(PAGE_BYTES));
    assign idx   = cnt_q[OFS_W-1:0];

    // R6: the period counter never passes its limit.
    a_r6_prog_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < CW'(LIMIT)));
endmodule

// File: rtl/pgmem_write_ctrl.sv
`timescale 1ns/1ps
// Paged write-load controller top: strobe qualifier, page buffer, programming
// timer, array model and read/status port.
// Assumes: MODEL_PAGES is a power of two and at least 2; page bits fold onto
// the model pages by XOR.
module pgmem_write_ctrl
    import pgw_pkg::*;
#(
    parameter int unsigned MODEL_PAGES      = 8,
    parameter int unsigned BYTE_WIN_CYCLES  = 18750,
    parameter int unsigned PROG_SLOW_CYCLES = 1250000,
    parameter int unsigned PROG_FAST_CYCLES = 375000,
    parameter bit          FAST_PROG        = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);
    localparam int unsigned PROG_SEL = FAST_PROG ? PROG_FAST_CYCLES : PROG_SLOW_CYCLES;
    localparam int unsigned PROG_LIM = (PROG_SEL < PAGE_BYTES) ? PAGE_BYTES : PROG_SEL;
    localparam int PSW = $clog2(MODEL_PAGES);
    localparam int MW  = PSW + OFS_W;

    logic              wr_fire, rd_fire, arr_we, prog_done, prog_sweep, tog_q;
    logic [ADDR_W-1:0] wr_addr, arr_addr;
    logic [DATA_W-1:0] last_data, arr_wdata;
    logic [OFS_W-1:0]  prog_idx;
    pg_state_e         st;
    logic [DATA_W-1:0] mem [MODEL_PAGES * PAGE_BYTES];

    function automatic logic [MW-1:0] model_idx(input logic [ADDR_W-1:0] a);
        logic [PSW-1:0] p;
        p = '0;
        for (int i = 0; i < PAGE_W; i++) p[i % PSW] ^= a[OFS_W + i];
        return {p, a[OFS_W-1:0]};
    endfunction

    pgw_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wr_fire(wr_fire), .wr_addr(wr_addr), .rd_fire(rd_fire)
    );

    pgw_page_ctrl #(.WIN_CYCLES(BYTE_WIN_CYCLES)) u_page (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
        .wr_data(din), .prog_done(prog_done), .prog_sweep(prog_sweep),
        .prog_idx(prog_idx), .st(st), .last_data(last_data), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    pgw_prog_seq #(.LIMIT(PROG_LIM)) u_prog (
        .clk(clk), .rst_n(rst_n), .run(st == PG_PROG), .done(prog_done),
        .sweep(prog_sweep), .idx(prog_idx)
    );

    assign busy = (st == PG_PROG);

    // Array model: contents survive reset.
    always_ff @(posedge clk) begin
        if (arr_we) mem[model_idx(arr_addr)] <= arr_wdata;
    end

    // Read port: array data when idle, polling/toggle status while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            tog_q <= 1'b0;
        end else if (rd_fire) begin
            if (busy) begin
                dout  <= {~last_data[7], tog_q ^ last_data[6], last_data[5:0]};
                tog_q <= ~tog_q;
            end else begin
                dout <= mem[model_idx(addr)];
            end
        end
    end

    // R7: a status read inverts bit 7 of the last accepted byte.
    a_r7_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && busy) |=> (dout[7] == ~$past(last_data[7])));
    // R8: every status read advances the toggle source.
    a_r8_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && busy) |=> (tog_q != $past(tog_q)));
endmodule

// File: tb/pgmem_write_ctrl_bench.sv
`timescale 1ns/1ps
module pgmem_write_ctrl_bench;
    localparam int WIN   = 24;
    localparam int PSLOW = 150;
    localparam int PFAST = 90;
    localparam int NPG   = 8;

    logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    wire  [7:0]  dout;
    wire         busy;

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    logic [7:0] model [NPG*64];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pgmem_write_ctrl #(
        .MODEL_PAGES(NPG), .BYTE_WIN_CYCLES(WIN), .PROG_SLOW_CYCLES(PSLOW),
        .PROG_FAST_CYCLES(PFAST), .FAST_PROG(1'b0)
    ) u_pgmem_write_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int aof(input int page, input int ofs);
        return page * 64 + ofs;
    endfunction

    // R9: wrong data while the write is active, wrong address once it has ended.
    task automatic wr_byte(input int page, input int ofs, input logic [7:0] d);
        @(negedge clk); cs_n = 0; we_n = 0; oe_n = 1; addr = 15'(aof(page, ofs)); din = ~d;
        @(negedge clk); we_n = 1; din = d; addr = 15'($urandom);
        @(negedge clk); cs_n = 1; din = 8'($urandom);
    endtask

    task automatic rd_byte(input int a, output logic [7:0] v);
        @(negedge clk); cs_n = 0; oe_n = 0; we_n = 1; addr = 15'(a);
        @(negedge clk); v = dout; cs_n = 1; oe_n = 1;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic wait_prog(output int len);
        int start;
        while (!busy) @(negedge clk);
        start = cyc;
        while (busy) @(negedge clk);
        len = cyc - start;
    endtask

    task automatic verify_page(input int page, input string req);
        logic [7:0] v;
        for (int o = 0; o < 64; o++) begin
            rd_byte(aof(page, o), v);
            check(v == model[page*64+o], req, v, model[page*64+o]);
        end
    endtask

    // Load chosen offsets in shuffled order, with occasional rewrites (R3).
    task automatic load_page(input int page, input logic [63:0] msk);
        int offs[64];
        int n, j, t, len;
        logic [7:0] d;
        n = 0;
        for (int o = 0; o < 64; o++) if (msk[o]) begin offs[n] = o; n++; end
        for (int i = n - 1; i > 0; i--) begin
            j = int'($urandom % (i + 1)); t = offs[i]; offs[i] = offs[j]; offs[j] = t;
        end
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            wr_byte(page, offs[i], d);
            model[page*64+offs[i]] = d;
            if (i > 0 && ($urandom % 6) == 0) begin
                d = 8'($urandom);
                wr_byte(page, offs[i-1], d);
                model[page*64+offs[i-1]] = d;
            end
        end
        wait_prog(len);
        check(len == PSLOW, "R6 programming length", len, PSLOW);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v, r1, r2, r3;
        int e0, len;
        logic [63:0] m;
        void'($urandom(32'd7321));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy == 1'b0, "R6 busy low after reset", busy, 0);
        check(dout == 8'h00, "R10 dout cleared by reset", dout, 0);

        // Page 0: in order, exact window close (R2) and programming length (R6).
        for (int o = 0; o < 64; o++) begin
            v = 8'($urandom); wr_byte(0, o, v); model[o] = v;
        end
        e0 = cyc;
        wait_cyc(e0 + WIN - 1);
        check(busy == 1'b0, "R2 busy still low one edge early", busy, 0);
        wait_cyc(e0 + WIN);
        check(busy == 1'b1, "R2 busy high on window edge", busy, 1);
        wait_prog(len);
        check(len == PSLOW, "R6 busy length", len, PSLOW);
        verify_page(0, "R1 R11 full page read-back");

        // Pages 1..7: whole pages in shuffled order (R1, R3).
        for (int p = 1; p < NPG; p++) begin
            load_page(p, '1);
            verify_page(p, "R3 shuffled full page");
        end

        // R3 directed: same offset rewritten, last value wins.
        wr_byte(2, 5, 8'h11); wr_byte(2, 3, 8'h22); wr_byte(2, 5, 8'h33);
        model[2*64+5] = 8'h33; model[2*64+3] = 8'h22;
        wait_prog(len);
        verify_page(2, "R3 R4 rewrite last wins");

        // R7/R8 status reads, R6 write while busy ignored.
        wr_byte(6, 10, 8'h4C); wr_byte(6, 20, 8'hB5);
        model[6*64+10] = 8'h4C; model[6*64+20] = 8'hB5;
        while (!busy) @(negedge clk);
        rd_byte(int'($urandom % 32768), r1);
        rd_byte(int'($urandom % 32768), r2);
        rd_byte(aof(6, 20), r3);
        check(r1[7] == 1'b0, "R7 polling bit inverted", r1[7], 0);
        check(r3[7] == 1'b0, "R7 polling bit on last address", r3[7], 0);
        check(r1[5:0] == 6'h35, "R7 low bits of last byte", r1[5:0], 6'h35);
        check(r2[6] != r1[6], "R8 bit6 toggles read 2", r2[6], !r1[6]);
        check(r3[6] != r2[6], "R8 bit6 toggles read 3", r3[6], !r2[6]);
        wr_byte(4, 0, ~model[4*64]);
        while (busy) @(negedge clk);
        e0 = cyc;
        wait_cyc(e0 + WIN + 5);
        check(busy == 1'b0, "R6 no window opened by busy write", busy, 0);
        rd_byte(aof(6, 20), r1);
        rd_byte(aof(6, 20), r2);
        check(r1 == 8'hB5, "R8 true data after programming", r1, 8'hB5);
        check(r2 == r1, "R8 bit6 steady when idle", r2, r1);
        rd_byte(aof(4, 0), v);
        check(v == model[4*64], "R6 busy write ignored", v, model[4*64]);
        verify_page(6, "R4 untouched neighbours");

        // R5: foreign-page strobes neither load nor extend the window.
        wr_byte(5, 1, 8'h5A); model[5*64+1] = 8'h5A;
        e0 = cyc;
        for (int k = 0; k < 4; k++) wr_byte(3, 7, ~model[3*64+7]);
        wait_cyc(e0 + WIN - 1);
        check(busy == 1'b0, "R5 window not extended (early)", busy, 0);
        wait_cyc(e0 + WIN);
        check(busy == 1'b1, "R5 window not extended (edge)", busy, 1);
        while (busy) @(negedge clk);
        rd_byte(aof(3, 7), v);
        check(v == model[3*64+7], "R5 foreign byte not programmed", v, model[3*64+7]);
        rd_byte(aof(5, 1), v);
        check(v == 8'h5A, "R5 open page byte programmed", v, 8'h5A);

        // R10: reset during a load drops it, array survives.
        wr_byte(1, 0, ~model[64]); wr_byte(1, 1, ~model[65]);
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(dout == 8'h00, "R10 dout cleared by reset", dout, 0);
        e0 = cyc;
        wait_cyc(e0 + WIN + 10);
        check(busy == 1'b0, "R10 partial load discarded", busy, 0);
        verify_page(1, "R10 array kept over reset");
        rd_byte(aof(0, 63), v);
        check(v == model[63], "R10 other page kept", v, model[63]);

        // Random sparse pages (R3, R4).
        for (int it = 0; it < 6; it++) begin
            m = {$urandom, $urandom} & {$urandom, $urandom};
            if (m == '0) m[it] = 1'b1;
            load_page(int'($urandom % NPG), m);
            for (int p = 0; p < NPG; p++) if (p == it % NPG) verify_page(p, "R4 sparse random page");
        end
        for (int p = 0; p < NPG; p++) verify_page(p, "R1 R4 final array");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule